// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. The line is sampled on the block clock, which acts as the receive clock and runs at 1, 16 or 64 times the baud rate. A frame begins with a falling edge on the idle-high line. In the oversampled modes, the block checks that edge again at the middle of the start bit, so that a short glitch cannot start a character. The block then collects 5 to 8 data bits, least significant first. An optional even or odd parity bit follows, and then a stop bit.

Each finished character goes into a holding register and raises a ready flag. The block reports a parity mismatch, a low stop bit and an overrun beside the character. It also reports a break, which is a line held low for a whole character. The host takes a character by pulsing a read strobe. The configuration arrives on plain input pins and must stay steady while a frame is being received.

Top module: `async_char_receiver`

## Requirements
- R1: After a synchronous active-low reset, `char_ready`, `parity_err`, `framing_err`, `overrun_err` and `break_det` are 0 and `char_data` is 0.
- R2: Data bits arrive least significant first. `len_sel` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `char_data` above the selected length read 0.
- R3: `factor_sel` code 0 selects ×1, code 1 selects ×16, and codes 2 and 3 select ×64 clocks per bit. In ×16 and ×64 modes every data, parity and stop bit is sampled at its centre. The centres are found by counting whole bit periods from the mid-start sample.
- R4: In ×16 and ×64 modes, the line is checked again at the middle of the start bit. If it reads high there, the falling edge is dropped as a false start: no character is delivered and the receiver waits for the next falling edge.
- R5: With `parity_on` = 1, one parity bit follows the data. With `parity_even` = 1, data plus parity must hold an even number of ones; with 0, an odd number. A mismatch sets `parity_err` together with `char_ready`. With `parity_on` = 0, no parity bit is expected and `parity_err` stays 0.
- R6: A stop bit sampled low sets `framing_err` together with `char_ready`.
- R7: `char_ready` rises when a character completes. A one-cycle `host_read` pulse clears `char_ready`, `parity_err`, `framing_err` and `overrun_err`.
- R8: If a character completes while `char_ready` is still 1 and no `host_read` comes in that cycle, `overrun_err` is set. The new character replaces the old one in `char_data`.
- R9: If every sample of a character is low, from the start bit through the stop bit, `break_det` is set. It clears once the line is back high. A line that stays low does not start another character.
- R10: In ×1 mode there is no mid-start check. The falling-edge clock is the start bit, and each following clock samples the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 1/16/64 times the baud rate |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_line | input | 1 | Serial data line, idles high |
| factor_sel | input | 2 | Clocks-per-bit code: 0 ×1, 1 ×16, 2/3 ×64 |
| len_sel | input | 2 | Data length code: 0..3 gives 5..8 bits |
| parity_on | input | 1 | 1 when a parity bit follows the data |
| parity_even | input | 1 | 1 for even parity, 0 for odd |
| host_read | input | 1 | One-cycle strobe: host takes the character |
| char_data | output | 8 | Last received character, right-aligned |
| char_ready | output | 1 | A character waits in the holding register |
| parity_err | output | 1 | Parity mismatch on the held character |
| framing_err | output | 1 | Stop bit of the held character read low |
| overrun_err | output | 1 | A character was replaced before it was read |
| break_det | output | 1 | Line low through a whole character |

## Verification
The bench drives a short low pulse in ×16 mode. A receiver without the mid-start check would treat that pulse as a start and deliver a spurious character, or lose the real frame that follows. It sends two characters with no read between them and checks that `overrun_err` is set and the second character is held; a design that dropped the newer byte or never set the flag fails there. It holds the line low across a full frame and then releases it, which catches a break flag that never sets, never clears, or lets a stuck-low line start a second frame. It also sends 5- and 6-bit characters with odd and even parity, a flipped parity bit, a low stop bit and a ×1 frame. These catch misaligned sampling, stale upper bits and inverted parity sense.

// File: rtl/rx_cfg_pkg.sv
// Shared types and helpers for the asynchronous character receiver.
// Assumes the factor code is 2 bits; code 3 aliases the largest factor.
package rx_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

    // Clocks per bit for a given factor code.
    function automatic int factor_cycles(input logic [1:0] code);
        case (code)
            2'd0:    factor_cycles = 1;
            2'd1:    factor_cycles = 16;
            default: factor_cycles = 64;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
// Brings the serial line into the clock domain and flags falling edges.
// Assumes the line idles high; the chain resets to all ones so that
// reset release cannot create a false edge.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], line_in};
    end

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign line_s = chain[STAGES-1];
    assign fall   = prev & ~chain[STAGES-1];
endmodule

// File: rtl/rx_frame_ctrl.sv
// Frame sequencer: start confirmation, bit-centre timing, data assembly,
// parity and stop evaluation. Emits a one-cycle done pulse with the
// character and its per-character flags. Assumes configuration is
// stable for the duration of a frame.
module rx_frame_ctrl
    import rx_cfg_pkg::*;
#(
    parameter int MAX_FACTOR = 64,
    parameter int MAX_BITS   = 8,
    parameter int MIN_BITS   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    input  logic                fall,
    input  logic [1:0]          factor_sel,
    input  logic [1:0]          len_sel,
    input  logic                parity_on,
    input  logic                parity_even,
    output logic                done,
    output logic [MAX_BITS-1:0] data,
    output logic                par_bad,
    output logic                stop_bad,
    output logic                all_low
);
    localparam int CNT_W = $clog2(MAX_FACTOR) + 1;
    localparam int IDX_W = $clog2(MAX_BITS);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  fmax;
    logic [CNT_W-1:0]  half;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic              tick;
    logic              par_acc;
    logic              par_seen;
    logic              low_acc;
    logic              exp_par;

    // Decode the configuration into bit timing and length limits.
    always_comb begin
        fmax     = CNT_W'(factor_cycles(factor_sel));
        half     = fmax >> 1;
        last_idx = IDX_W'(len_sel) + IDX_W'(MIN_BITS - 1);
        tick     = (cnt == fmax - CNT_W'(1));
        exp_par  = parity_even ? par_acc : ~par_acc;
    end

    // Main frame state machine with its bit counter and data assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            data     <= '0;
            par_acc  <= 1'b0;
            par_seen <= 1'b0;
            low_acc  <= 1'b0;
            done     <= 1'b0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            all_low  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (fall) begin
                        data     <= '0;
                        bit_idx  <= '0;
                        par_acc  <= 1'b0;
                        par_seen <= 1'b0;
                        low_acc  <= 1'b1;
                        state    <= (fmax == CNT_W'(1)) ? ST_DATA : ST_START;
                    end
                end
                ST_START: begin
                    if (cnt == half - CNT_W'(1)) begin
                        cnt   <= '0;
                        state <= line ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        cnt           <= '0;
                        data[bit_idx] <= line;
                        par_acc       <= par_acc ^ line;
                        low_acc       <= low_acc & ~line;
                        if (bit_idx == last_idx)
                            state <= parity_on ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + IDX_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PAR: begin
                    if (tick) begin
                        cnt      <= '0;
                        par_seen <= line;
                        low_acc  <= low_acc & ~line;
                        state    <= ST_STOP;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        cnt      <= '0;
                        done     <= 1'b1;
                        par_bad  <= parity_on & (par_seen != exp_par);
                        stop_bad <= ~line;
                        all_low  <= low_acc & ~line;
                        state    <= ST_IDLE;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: a high line at the mid-start check returns to hunting.
    assert_false_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && cnt == half - CNT_W'(1) && line) |=> (state == ST_IDLE && !done));

    // R3: the bit counter never reaches the bit period.
    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < fmax));

    // R9: a break frame always also has a low stop bit.
    assert_break_implies_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_low) |-> stop_bad);
endmodule

// File: rtl/rx_holding.sv
// Receive holding register plus the host-visible ready and error flags.
// Assumes host_read is a single-cycle strobe; a completion in the same
// cycle as a read wins and is not counted as an overrun.
module rx_holding #(
    parameter int MAX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic                par_bad,
    input  logic                stop_bad,
    input  logic                all_low,
    input  logic                line_s,
    input  logic                host_read,
    output logic [MAX_BITS-1:0] char_data,
    output logic                char_ready,
    output logic                parity_err,
    output logic                framing_err,
    output logic                overrun_err,
    output logic                break_det
);
    // Capture a completed character or clear flags on a host read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_data   <= '0;
            char_ready  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            overrun_err <= 1'b0;
        end else if (done) begin
            char_data   <= data_in;
            char_ready  <= 1'b1;
            parity_err  <= par_bad;
            framing_err <= stop_bad;
            overrun_err <= (char_ready | overrun_err) & ~host_read;
        end else if (host_read) begin
            char_ready  <= 1'b0;
            parity_err  <= 1'b0;
            framing_err <= 1'b0;
            overrun_err <= 1'b0;
        end
    end

    // Track the break condition until the line returns high.
    always_ff @(posedge clk) begin
        if (!rst_n)                break_det <= 1'b0;
        else if (done && all_low)  break_det <= 1'b1;
        else if (line_s)           break_det <= 1'b0;
    end

    // R7: every completion leaves a character ready.
    assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> char_ready);

    // R7: a read with no completion empties the holding register.
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_read && !done) |=> (!char_ready && !overrun_err));

    // R8: completing onto an unread character flags overrun.
    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && char_ready && !host_read) |=> overrun_err);

    // R9: a high line with no completion clears break.
    assert_break_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_s && !done) |=> !break_det);
endmodule

// File: rtl/async_char_receiver.sv
// Top of the asynchronous character receiver: line synchroniser, frame
// sequencer and holding register. Assumes the block clock is the receive
// clock at the selected multiple of the baud rate.
module async_char_receiver #(
    parameter int MAX_FACTOR  = 64,
    parameter int MAX_BITS    = 8,
    parameter int MIN_BITS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic [1:0] factor_sel,
    input  logic [1:0] len_sel,
    input  logic       parity_on,
    input  logic       parity_even,
    input  logic       host_read,
    output logic [7:0] char_data,
    output logic       char_ready,
    output logic       parity_err,
    output logic       framing_err,
    output logic       overrun_err,
    output logic       break_det
);
    logic                line_s;
    logic                fall;
    logic                done;
    logic [MAX_BITS-1:0] frame_data;
    logic [MAX_BITS-1:0] held;
    logic                par_bad;
    logic                stop_bad;
    logic                all_low;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .line_s  (line_s),
        .fall    (fall)
    );

    rx_frame_ctrl #(
        .MAX_FACTOR (MAX_FACTOR),
        .MAX_BITS   (MAX_BITS),
        .MIN_BITS   (MIN_BITS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .line        (line_s),
        .fall        (fall),
        .factor_sel  (factor_sel),
        .len_sel     (len_sel),
        .parity_on   (parity_on),
        .parity_even (parity_even),
        .done        (done),
        .data        (frame_data),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad),
        .all_low     (all_low)
    );

    rx_holding #(.MAX_BITS(MAX_BITS)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (done),
        .data_in     (frame_data),
        .par_bad     (par_bad),
        .stop_bad    (stop_bad),
        .all_low     (all_low),
        .line_s      (line_s),
        .host_read   (host_read),
        .char_data   (held),
        .char_ready  (char_ready),
        .parity_err  (parity_err),
        .framing_err (framing_err),
        .overrun_err (overrun_err),
        .break_det   (break_det)
    );

    assign char_data = 8'(held);
endmodule

// File: tb/tb_async_char_receiver.sv
module tb_async_char_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] factor_sel = 2'd1;
    logic [1:0] len_sel = 2'd3;
    logic       parity_on = 1'b0;
    logic       parity_even = 1'b0;
    logic       host_read = 1'b0;
    logic [7:0] char_data;
    logic       char_ready, parity_err, framing_err, overrun_err, break_det;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    async_char_receiver dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .factor_sel(factor_sel), .len_sel(len_sel),
        .parity_on(parity_on), .parity_even(parity_even),
        .host_read(host_read), .char_data(char_data),
        .char_ready(char_ready), .parity_err(parity_err),
        .framing_err(framing_err), .overrun_err(overrun_err),
        .break_det(break_det)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int fac);
        @(negedge clk);
        rx_line = v;
        repeat (fac - 1) @(negedge clk);
    endtask

    task automatic config_rx(input int fac, input int len, input bit pen, input bit peven);
        @(negedge clk);
        factor_sel  = (fac == 1) ? 2'd0 : (fac == 16) ? 2'd1 : 2'd2;
        len_sel     = 2'(len - 5);
        parity_on   = pen;
        parity_even = peven;
    endtask

    function automatic logic par_of(input logic [7:0] d, input int len, input bit peven);
        logic x = 1'b0;
        for (int i = 0; i < len; i++) x ^= d[i];
        return peven ? x : ~x;
    endfunction

    // Frame: start, len data bits, optional parity bit, stop, then idle.
    task automatic send_frame(input int fac, input logic [7:0] d, input int len,
                              input bit pen, input logic pbit, input logic stopv);
        drive_bit(1'b0, fac);
        for (int i = 0; i < len; i++) drive_bit(d[i], fac);
        if (pen) drive_bit(pbit, fac);
        drive_bit(stopv, fac);
        drive_bit(1'b1, 8);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); host_read = 1'b1;
        @(negedge clk); host_read = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 ready", char_ready, 0);
        chk("R1 data", char_data, 0);
        chk("R1 errors", {parity_err, framing_err, overrun_err}, 0);
        chk("R1 break", break_det, 0);
    endtask

    task automatic t_x16_even();
        config_rx(16, 8, 1, 1);
        send_frame(16, 8'hA7, 8, 1, par_of(8'hA7, 8, 1), 1'b1);
        chk("R3 x16 data", char_data, 8'hA7);
        chk("R7 ready set", char_ready, 1);
        chk("R5 even parity ok", parity_err, 0);
        chk("R6 good stop", framing_err, 0);
        do_read();
        chk("R7 read clears ready", char_ready, 0);
    endtask

    task automatic t_x64_len5_odd();
        config_rx(64, 5, 1, 0);
        send_frame(64, 8'h16, 5, 1, par_of(8'h16, 5, 0), 1'b1);
        chk("R2 len5 data", char_data, 8'h16);
        chk("R5 odd parity ok", parity_err, 0);
        do_read();
    endtask

    task automatic t_len6_upper_zero();
        config_rx(16, 6, 0, 0);
        send_frame(16, 8'hFF, 6, 0, 1'b0, 1'b1);
        chk("R2 len6 upper bits zero", char_data, 8'h3F);
        chk("R5 no parity no error", parity_err, 0);
        do_read();
    endtask

    task automatic t_parity_err();
        config_rx(16, 7, 1, 1);
        send_frame(16, 8'h55, 7, 1, ~par_of(8'h55, 7, 1), 1'b1);
        chk("R5 parity error", parity_err, 1);
        chk("R5 data with parity error", char_data, 8'h55);
        do_read();
        chk("R7 read clears parity error", parity_err, 0);
    endtask

    task automatic t_framing_err();
        config_rx(16, 8, 0, 0);
        send_frame(16, 8'h3C, 8, 0, 1'b0, 1'b0);
        chk("R6 framing error", framing_err, 1);
        chk("R6 break not set for data", break_det, 0);
        do_read();
    endtask

    task automatic t_false_start();
        config_rx(16, 8, 0, 0);
        drive_bit(1'b0, 4);
        drive_bit(1'b1, 60);
        chk("R4 glitch gives no char", char_ready, 0);
        send_frame(16, 8'h81, 8, 0, 1'b0, 1'b1);
        chk("R4 frame after glitch", char_data, 8'h81);
        do_read();
    endtask

    task automatic t_overrun();
        config_rx(16, 8, 0, 0);
        send_frame(16, 8'h11, 8, 0, 1'b0, 1'b1);
        chk("R8 no overrun first", overrun_err, 0);
        send_frame(16, 8'h22, 8, 0, 1'b0, 1'b1);
        chk("R8 overrun set", overrun_err, 1);
        chk("R8 newer char kept", char_data, 8'h22);
        do_read();
        chk("R7 read clears overrun", overrun_err, 0);
    endtask

    task automatic t_break();
        config_rx(16, 8, 1, 1);
        drive_bit(1'b0, 16 * 11 + 40);
        chk("R9 break set", break_det, 1);
        chk("R9 break frame error", framing_err, 1);
        chk("R9 single char while low", overrun_err, 0);
        drive_bit(1'b1, 6);
        chk("R9 break cleared", break_det, 0);
        chk("R9 no new char on release", overrun_err, 0);
        do_read();
    endtask

    task automatic t_x1();
        config_rx(1, 8, 0, 0);
        send_frame(1, 8'hC6, 8, 0, 1'b0, 1'b1);
        chk("R10 x1 data", char_data, 8'hC6);
        chk("R10 x1 ready", char_ready, 1);
        do_read();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_x16_even();
        t_x64_len5_odd();
        t_len6_upper_zero();
        t_parity_err();
        t_framing_err();
        t_false_start();
        t_overrun();
        t_break();
        t_x1();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule